// File: doc/BRIEF.md
# Interrupt Vector Dispatch Unit

This block turns interrupt level lines into interrupt-vector numbers and posts them into a single-slot vector-receive register on the processor side. There are two groups of inputs. A bank of 64 direct vector lines names a vector by its position. A bank of 16 legacy bus interrupt lines is translated through a fixed sparse table, and most of those lines have no vector at all.

The block registers every input and detects each level change. In each cycle one change is served. A rising level loads the receive register, but only when the register is free. It then sets the busy flag and raises the vector-interrupt request. A falling level frees the register and drops the request. Software reads the busy flag through an 8-bit status byte and reads three 64-bit data words. Queuing of vectors and any acknowledge path beyond the free operation are left to the surrounding logic.

Top module: `vec_dispatch_unit`

## Requirements
- R1: The legacy lines map to vectors as follows. Line 7 maps to 0x22, line 6 to 0x27, line 1 to 0x29, line 12 to 0x2a and line 4 to 0x2b. A change on a mapped line behaves like the same change on that vector.
- R2: A change on a legacy line without a table entry (vector 0) has no effect on any output.
- R3: When a rising level is served while the register is free, the busy flag, status bit 5 (value 0x20) and the request output are all 1 after the next clock edge.
- R4: On a load, data word 0 becomes (0x1f << 6) | vector, where the vector is 6 bits, so it equals 0x7c0 + vector. Data words 1 and 2 become zero.
- R5: A rising level served while busy is ignored. Busy stays set and all data words keep their values.
- R6: A falling level served while busy clears busy, status bit 5 and the request. The data words keep their last values.
- R7: A falling level served while the register is free changes no output.
- R8: When a direct vector line and a legacy line change in the same cycle, only the direct change is served.
- R9: Among simultaneous changes within the same group, the one with the lowest vector number is served. The other changes in that cycle are dropped.
- R10: Reset clears busy, the request, the status byte and all three data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_lvl | input | 64 | Direct vector interrupt levels, bit n names vector n |
| leg_lvl | input | 16 | Legacy bus interrupt levels |
| rx_busy | output | 1 | Receive register holds a vector |
| rx_status | output | 8 | Receive status, bit 5 is busy, other bits zero |
| rx_data0 | output | 64 | Data word 0: tag 0x1f at bits 10:6, vector at bits 5:0 |
| rx_data1 | output | 64 | Data word 1, zero on load |
| rx_data2 | output | 64 | Data word 2, zero on load |
| vec_irq | output | 1 | Vector-interrupt request to the processor |

## Verification
The assertions assume that the level inputs are quiet when reset is released. A line that is already high at release would look like a fresh raise. They also assume that no two legacy lines share a vector, so a legacy change never carries both directions for one vector. The stimulus holds all levels low across every reset. It only drives legacy lines from the fixed table or from lines that have no entry. It changes inputs only on the falling clock edge, so each step produces exactly one served change.

// File: rtl/vdu_pkg.sv
package vdu_pkg;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_RAISE = 2'd1,
        EV_LOWER = 2'd2
    } vdu_evt_e;

    // Legacy line to vector translation; 0 means the line is not wired.
    function automatic int legacy_vec(input int line);
        case (line)
            1:       return 'h29;
            4:       return 'h2b;
            6:       return 'h27;
            7:       return 'h22;
            12:      return 'h2a;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/vdu_edge.sv
module vdu_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise[i] = lvl[i] & ~prev_q[i];
        assign fall[i] = ~lvl[i] & prev_q[i];
    end
endmodule

// File: rtl/vdu_pick.sv
module vdu_pick
    import vdu_pkg::*;
#(
    parameter int NUM_VEC = 64,
    parameter int NUM_LEG = 16,
    parameter int VEC_W   = $clog2(NUM_VEC)
) (
    input  logic [NUM_VEC-1:0] d_rise,
    input  logic [NUM_VEC-1:0] d_fall,
    input  logic [NUM_LEG-1:0] l_rise,
    input  logic [NUM_LEG-1:0] l_fall,
    output vdu_evt_e           evt,
    output logic [VEC_W-1:0]   evt_vec
);
    logic [NUM_VEC-1:0] lv_rise, lv_fall;

    // Fold the legacy lines onto the vector space.
    always_comb begin
        lv_rise = '0;
        lv_fall = '0;
        for (int i = 0; i < NUM_LEG; i++) begin
            int m;
            m = legacy_vec(i);
            if (m != 0 && m < NUM_VEC) begin
                lv_rise[m] = lv_rise[m] | l_rise[i];
                lv_fall[m] = lv_fall[m] | l_fall[i];
            end
        end
    end

    // Lowest vector wins; direct lines override legacy ones.
    always_comb begin
        evt     = EV_NONE;
        evt_vec = '0;
        for (int v = NUM_VEC - 1; v >= 0; v--) begin
            if (lv_rise[v] | lv_fall[v]) begin
                evt     = lv_rise[v] ? EV_RAISE : EV_LOWER;
                evt_vec = VEC_W'(v);
            end
        end
        if (|(d_rise | d_fall)) begin
            for (int v = NUM_VEC - 1; v >= 0; v--) begin
                if (d_rise[v] | d_fall[v]) begin
                    evt     = d_rise[v] ? EV_RAISE : EV_LOWER;
                    evt_vec = VEC_W'(v);
                end
            end
        end
    end
endmodule

// File: rtl/vdu_recv.sv
module vdu_recv
    import vdu_pkg::*;
#(
    parameter int         DATA_W = 64,
    parameter int         VEC_W  = 6,
    parameter logic [4:0] TAG    = 5'h1f
) (
    input  logic              clk,
    input  logic              rst_n,
    input  vdu_evt_e          evt,
    input  logic [VEC_W-1:0]  evt_vec,
    output logic              busy,
    output logic [DATA_W-1:0] data0,
    output logic [DATA_W-1:0] data1,
    output logic [DATA_W-1:0] data2
);
    typedef struct packed {
        logic              busy;
        logic [DATA_W-1:0] w0;
        logic [DATA_W-1:0] w1;
        logic [DATA_W-1:0] w2;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt == EV_RAISE && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.w0   = (DATA_W'(TAG) << VEC_W) | DATA_W'(evt_vec);
            st_d.w1   = '0;
            st_d.w2   = '0;
        end else if (evt == EV_LOWER && st_q.busy) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy  = st_q.busy;
    assign data0 = st_q.w0;
    assign data1 = st_q.w1;
    assign data2 = st_q.w2;

    p_load_on_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == EV_RAISE && !busy) |=> busy);

    p_load_format_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == EV_RAISE && !busy) |=> (data1 == '0 && data2 == '0 &&
            data0[VEC_W +: 5] == TAG && data0[VEC_W-1:0] == $past(evt_vec)));

    p_busy_holds_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && evt != EV_LOWER) |=> (busy && $stable(data0) && $stable(data1)));

    p_lower_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == EV_LOWER && busy) |=> (!busy && $stable(data0)));

    p_idle_lower_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == EV_LOWER && !busy) |=> (!busy && $stable(data0)));

    p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == EV_NONE) |=> ($stable(busy) && $stable(data0)));
endmodule

// File: rtl/vec_dispatch_unit.sv
module vec_dispatch_unit
    import vdu_pkg::*;
#(
    parameter int         NUM_VEC = 64,
    parameter int         NUM_LEG = 16,
    parameter int         DATA_W  = 64,
    parameter int         STAT_W  = 8,
    parameter int         BUSY_BIT = 5,
    parameter logic [4:0] TAG     = 5'h1f
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] vec_lvl,
    input  logic [NUM_LEG-1:0] leg_lvl,
    output logic               rx_busy,
    output logic [STAT_W-1:0]  rx_status,
    output logic [DATA_W-1:0]  rx_data0,
    output logic [DATA_W-1:0]  rx_data1,
    output logic [DATA_W-1:0]  rx_data2,
    output logic               vec_irq
);
    localparam int VEC_W = $clog2(NUM_VEC);

    logic [NUM_VEC-1:0] d_rise, d_fall;
    logic [NUM_LEG-1:0] l_rise, l_fall;
    vdu_evt_e           evt;
    logic [VEC_W-1:0]   evt_vec;

    vdu_edge #(.W(NUM_VEC)) u_dir_edge (
        .clk(clk), .rst_n(rst_n), .lvl(vec_lvl), .rise(d_rise), .fall(d_fall)
    );

    vdu_edge #(.W(NUM_LEG)) u_leg_edge (
        .clk(clk), .rst_n(rst_n), .lvl(leg_lvl), .rise(l_rise), .fall(l_fall)
    );

    vdu_pick #(.NUM_VEC(NUM_VEC), .NUM_LEG(NUM_LEG), .VEC_W(VEC_W)) u_pick (
        .d_rise(d_rise), .d_fall(d_fall), .l_rise(l_rise), .l_fall(l_fall),
        .evt(evt), .evt_vec(evt_vec)
    );

    vdu_recv #(.DATA_W(DATA_W), .VEC_W(VEC_W), .TAG(TAG)) u_recv (
        .clk(clk), .rst_n(rst_n), .evt(evt), .evt_vec(evt_vec),
        .busy(rx_busy), .data0(rx_data0), .data1(rx_data1), .data2(rx_data2)
    );

    always_comb begin
        rx_status           = '0;
        rx_status[BUSY_BIT] = rx_busy;
    end
    assign vec_irq = rx_busy;

    p_direct_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(d_rise | d_fall)) |-> (evt != EV_NONE && (d_rise[evt_vec] || d_fall[evt_vec])));

    p_lowest_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != EV_NONE && (|(d_rise | d_fall))) |->
            (((d_rise | d_fall) & ((NUM_VEC'(1) << evt_vec) - NUM_VEC'(1))) == '0));
endmodule

// File: tb/vec_dispatch_unit_tb_top.sv
module vec_dispatch_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] vec_lvl = '0;
    logic [15:0] leg_lvl = '0;
    logic        rx_busy, vec_irq;
    logic [7:0]  rx_status;
    logic [63:0] rx_data0, rx_data1, rx_data2;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    typedef struct {
        logic        busy;
        logic [63:0] d0;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    vec_dispatch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .vec_lvl(vec_lvl), .leg_lvl(leg_lvl),
        .rx_busy(rx_busy), .rx_status(rx_status), .rx_data0(rx_data0),
        .rx_data1(rx_data1), .rx_data2(rx_data2), .vec_irq(vec_irq)
    );

    task automatic compare(input exp_t e);
        n_checks++;
        if (rx_busy !== e.busy || vec_irq !== e.busy || rx_status !== {2'b0, e.busy, 5'b0}
            || rx_data0 !== e.d0 || rx_data1 !== 64'd0 || rx_data2 !== 64'd0) begin
            n_fails++;
            $display("FAIL %s: busy=%b irq=%b stat=%h d0=%h d1=%h d2=%h exp busy=%b stat=%h d0=%h d1=0 d2=0",
                     e.tag, rx_busy, vec_irq, rx_status, rx_data0, rx_data1, rx_data2,
                     e.busy, {2'b0, e.busy, 5'b0}, e.d0);
        end
    endtask

    // Monitor: results appear after the edge following the stimulus.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) compare(sb_q.pop_front());
        end
    end

    task automatic step(input logic [63:0] v, input logic [15:0] l,
                        input logic eb, input logic [63:0] ed, input string tag);
        exp_t e;
        @(negedge clk);
        vec_lvl = v;
        leg_lvl = l;
        e.busy = eb; e.d0 = ed; e.tag = tag;
        sb_q.push_back(e);
    endtask

    function automatic logic [63:0] w0(input int vec);
        return 64'h7c0 | 64'(vec);
    endfunction

    function automatic logic [63:0] dv(input int n);
        return 64'd1 << n;
    endfunction

    function automatic logic [15:0] lb(input int n);
        return 16'd1 << n;
    endfunction

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        r.busy = 1'b0; r.d0 = '0; r.tag = "R10 reset state";
        compare(r);
        // R1/R3/R4: legacy line 1 -> 0x29
        step('0, lb(1), 1, w0('h29), "R1 R3 R4 line1 raise");
        step('0, '0,    0, w0('h29), "R6 line1 lower");
        // R3/R5/R6/R7 with a direct vector
        step(dv(5), '0,     1, w0(5), "R3 direct 5 raise");
        step(dv(5), lb(4),  1, w0(5), "R5 raise while busy ignored");
        step('0,    lb(4),  0, w0(5), "R6 direct 5 lower");
        step('0,    '0,     0, w0(5), "R7 lower while idle");
        // R2: unmapped legacy lines
        step('0, lb(3),            0, w0(5), "R2 unmapped line3 raise");
        step('0, lb(3) | lb(0),    0, w0(5), "R2 unmapped line0 raise");
        step('0, '0,               0, w0(5), "R2 unmapped lower");
        // R1: the rest of the table
        step('0, lb(4),  1, w0('h2b), "R1 line4");
        step('0, '0,     0, w0('h2b), "R6 line4 lower");
        step('0, lb(6),  1, w0('h27), "R1 line6");
        step('0, '0,     0, w0('h27), "R6 line6 lower");
        step('0, lb(7),  1, w0('h22), "R1 line7");
        step('0, '0,     0, w0('h22), "R6 line7 lower");
        step('0, lb(12), 1, w0('h2a), "R1 line12");
        step('0, '0,     0, w0('h2a), "R6 line12 lower");
        // R8: direct 40 beats legacy line 7 (vector 0x22 is lower)
        step(dv(40), lb(7), 1, w0(40), "R8 direct over legacy");
        step('0,     '0,    0, w0(40), "R8 direct lower served");
        // R9: lowest vector wins within a group
        step(dv(9) | dv(3), '0, 1, w0(3), "R9 direct 3 over 9");
        step('0, '0,            0, w0(3), "R9 lower");
        step('0, lb(1) | lb(6), 1, w0('h27), "R9 legacy 0x27 over 0x29");
        step('0, '0,            0, w0('h27), "R9 legacy lower");
        step(dv(0), '0, 1, w0(0), "R4 vector zero");
        step('0,    '0, 0, w0(0), "R6 vector zero lower");
        // R10: reset while busy
        step(dv(2), '0, 1, w0(2), "R3 direct 2 raise");
        @(negedge clk);
        while (sb_q.size() > 0) @(negedge clk);
        vec_lvl = '0;
        rst_n = 1'b0;
        #1;
        r.busy = 1'b0; r.d0 = '0; r.tag = "R10 reset while busy";
        compare(r);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule